// File: doc/BRIEF.md
# Dual-Output Interrupt Controller Register Bank

This block is the software-visible register bank of an interrupt controller that serves 51 sources. A separate capture unit turns the source pins into a raw pending vector. This bank takes that vector and masks it with a per-source enable. A per-source select bit then steers each source to one of two combined outputs: a normal interrupt request and a fast interrupt request. The bank also drives the per-source configuration that the capture unit needs: level versus edge sensing, active polarity, and both-edge detection. Alongside these it sends a one-cycle strobe vector that tells the capture unit which latched edge events to drop.

The 51 source bits are held internally as a single wide vector. Software sees them through a 32-bit single-cycle register port. Two address maps are decoded. The compact map (offsets below 0x80) reaches only the low word. The split map (offsets 0x80 and above) uses address bit 2 to choose between the low word (sources 0 to 31) and the high word (sources 32 to 50). Enable has separate set and clear addresses, so software never needs a read-modify-write sequence to change one source.

Top module: `irq_fiq_regbank`

## Requirements
- R1: For byte offsets at or above 0x80, address bit 2 selects the high word and is then ignored by the decode. A high-word read returns sources 32..50 in data bits 18..0, with bits 31..19 reading 0. Offsets below 0x80 always reach the low word (sources 0..31).
- R2: The raw vector reads at 0x90 (compact 0x08). IRQ status reads raw & enable & ~select at 0x80 (compact 0x00). FIQ status reads raw & enable & select at 0x88 (compact 0x04).
- R3: The select register reads and writes at 0x98 (compact 0x0C). A write replaces only the addressed word and leaves the other word unchanged. A select bit of 1 routes that source to the fast output.
- R4: Writing ones to 0xA0 (compact 0x10) sets enable bits. Writing ones to 0xA8 (compact 0x14) clears enable bits. Zero bits leave enable unchanged. Enable reads at 0xA0 (compact 0x10).
- R5: irqOut is 1 exactly when raw & enable & ~select is nonzero. fiqOut is 1 exactly when raw & enable & select is nonzero. Both follow their inputs in the same cycle.
- R6: Sensitivity (1 = level) is constant at 0x1F07FFF8FFFF and both-edge is constant at 0xF800070000. They read at 0xC0 (compact 0x24) and 0xC8 (compact 0x28), and they drive senseLvl and bothEdge.
- R7: Edge status at 0xE0 reads raw & ~sensitivity.
- R8: Polarity resets to 0x5F07FFF8FFFF and reads at 0xD0 (compact 0x2C). Only a write to the high word (0xD4) changes it, and only sources 47..50 (data bits 15..18). A write to 0xD0 is ignored. Polarity drives polHigh.
- R9: Writing to 0xD8 (compact 0x38) pulses edgeClr for that one cycle. The pulse equals the written word placed at the addressed word's position and masked to edge-sensed sources. In every other cycle edgeClr is 0.
- R10: Reads of write-only addresses (0xA8, 0xB8, 0xD8), of the software-interrupt address (0xB0, compact 0x18) and of undecoded addresses return 0.
- R11: Writes to read-only, software-interrupt or undecoded addresses change no state.
- R12: After reset, enable and select read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regSel | input | 1 | Register access valid this cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle |
| rawPend | input | 51 | Raw pending vector from the capture unit |
| irqOut | output | 1 | Combined normal interrupt request |
| fiqOut | output | 1 | Combined fast interrupt request |
| senseLvl | output | 51 | Per-source sensing, 1 = level |
| polHigh | output | 51 | Per-source polarity, 1 = high or rising |
| bothEdge | output | 51 | Per-source both-edge detection |
| edgeClr | output | 51 | One-cycle clear strobe for latched edges |

## Verification
Some rules are checked on every cycle: edgeClr never touches a level-sensed source and is silent outside a write, a zero raw vector keeps both outputs low, high-word reads pad with zeros, write-only addresses read 0, and a low-word polarity write leaves polarity unchanged. Other behaviour can only be shown by bench scenarios that keep a running model of enable, select and polarity under random access sequences. That covers word-preserving select writes, set/clear enable semantics, the status reads that combine raw, enable and select, and the absence of effects from writes to read-only addresses.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_IRQST,
    RD_FIQST,
    RD_RAW,
    RD_SEL,
    RD_EN,
    RD_SENSE,
    RD_BOTH,
    RD_POL,
    RD_EDGEST
  } rdSrcE;

  typedef struct packed {
    logic  hiWord;
    logic  wrSel;
    logic  enSet;
    logic  enClr;
    logic  wrPol;
    logic  edgeClr;
    rdSrcE rdSrc;
  } ctrlStrobeT;

  localparam int unsigned NEW_MAP_BASE = 'h80;
  localparam logic [63:0] SENSE_RST = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [63:0] BOTH_RST  = 64'h0000_00F8_0007_0000;
  localparam logic [63:0] POL_RST   = 64'h0000_5F07_FFF8_FFFF;

endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobeT        strb
);

  // split map offsets (bit 2 already stripped)
  localparam logic [ADDR_W-1:0] N_IRQST  = ADDR_W'('h80);
  localparam logic [ADDR_W-1:0] N_FIQST  = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] N_RAW    = ADDR_W'('h90);
  localparam logic [ADDR_W-1:0] N_SEL    = ADDR_W'('h98);
  localparam logic [ADDR_W-1:0] N_ENSET  = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] N_ENCLR  = ADDR_W'('hA8);
  localparam logic [ADDR_W-1:0] N_SENSE  = ADDR_W'('hC0);
  localparam logic [ADDR_W-1:0] N_BOTH   = ADDR_W'('hC8);
  localparam logic [ADDR_W-1:0] N_POL    = ADDR_W'('hD0);
  localparam logic [ADDR_W-1:0] N_ECLR   = ADDR_W'('hD8);
  localparam logic [ADDR_W-1:0] N_EDGEST = ADDR_W'('hE0);
  // compact map offsets
  localparam logic [ADDR_W-1:0] C_IRQST  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] C_FIQST  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] C_RAW    = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] C_SEL    = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] C_ENSET  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] C_ENCLR  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] C_SENSE  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] C_BOTH   = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] C_POL    = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] C_ECLR   = ADDR_W'('h38);

  logic              newMap;
  logic              hiSel;
  logic [ADDR_W-1:0] normOff;

  always_comb begin
    newMap  = (regAddr >= ADDR_W'(NEW_MAP_BASE));
    hiSel   = newMap & regAddr[2];
    normOff = newMap ? (regAddr & ~ADDR_W'(4)) : regAddr;

    strb        = '0;
    strb.hiWord = hiSel;
    strb.rdSrc  = RD_ZERO;

    if (regSel && !regWr) begin
      case (normOff)
        N_IRQST,  C_IRQST: strb.rdSrc = RD_IRQST;
        N_FIQST,  C_FIQST: strb.rdSrc = RD_FIQST;
        N_RAW,    C_RAW:   strb.rdSrc = RD_RAW;
        N_SEL,    C_SEL:   strb.rdSrc = RD_SEL;
        N_ENSET,  C_ENSET: strb.rdSrc = RD_EN;
        N_SENSE,  C_SENSE: strb.rdSrc = RD_SENSE;
        N_BOTH,   C_BOTH:  strb.rdSrc = RD_BOTH;
        N_POL,    C_POL:   strb.rdSrc = RD_POL;
        N_EDGEST:          strb.rdSrc = RD_EDGEST;
        default:           strb.rdSrc = RD_ZERO;
      endcase
    end

    if (regSel && regWr) begin
      case (normOff)
        N_SEL,   C_SEL:   strb.wrSel   = 1'b1;
        N_ENSET, C_ENSET: strb.enSet   = 1'b1;
        N_ENCLR, C_ENCLR: strb.enClr   = 1'b1;
        N_POL:            strb.wrPol   = hiSel;
        N_ECLR,  C_ECLR:  strb.edgeClr = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irqbank_dp.sv
module irqbank_dp
  import irqbank_pkg::*;
#(
  parameter int          NUM_SRC    = 51,
  parameter int          DATA_W     = 32,
  parameter int          POL_W      = 4,
  parameter logic [63:0] SENSE_INIT = SENSE_RST,
  parameter logic [63:0] BOTH_INIT  = BOTH_RST,
  parameter logic [63:0] POL_INIT   = POL_RST
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] rawPend,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqReq,
  output logic               fiqReq,
  output logic [NUM_SRC-1:0] senseVec,
  output logic [NUM_SRC-1:0] bothVec,
  output logic [NUM_SRC-1:0] polVec,
  output logic [NUM_SRC-1:0] edgeClrVec
);

  localparam int HI_W    = NUM_SRC - DATA_W;
  localparam int NWORDS  = 2;
  localparam int PAD_W   = NWORDS * DATA_W;
  localparam int FIX_W   = NUM_SRC - POL_W;

  logic [NUM_SRC-1:0] selReg;
  logic [NUM_SRC-1:0] enReg;
  logic [POL_W-1:0]   polReg;
  logic [NUM_SRC-1:0] wideData;
  logic [NUM_SRC-1:0] qualPend;
  logic [NUM_SRC-1:0] rdVec;
  logic [PAD_W-1:0]   rdPad;
  logic [DATA_W-1:0]  wordArr [NWORDS];

  // place the written word at the addressed position
  always_comb begin
    if (strb.hiWord) wideData = {wdata[HI_W-1:0], {DATA_W{1'b0}}};
    else             wideData = NUM_SRC'(wdata);
  end

  // select: word-replace semantics
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (strb.wrSel) begin
      if (strb.hiWord) selReg[NUM_SRC-1:DATA_W] <= wdata[HI_W-1:0];
      else             selReg[DATA_W-1:0]       <= wdata;
    end
  end

  // enable: separate set and clear addresses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enReg <= '0;
    else if (strb.enSet)  enReg <= enReg | wideData;
    else if (strb.enClr)  enReg <= enReg & ~wideData;
  end

  // polarity: only the top sources are writable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           polReg <= POL_INIT[NUM_SRC-1 -: POL_W];
    else if (strb.wrPol) polReg <= wdata[HI_W-1 -: POL_W];
  end

  assign polVec   = {polReg, POL_INIT[FIX_W-1:0]};
  assign senseVec = SENSE_INIT[NUM_SRC-1:0];
  assign bothVec  = BOTH_INIT[NUM_SRC-1:0];

  assign qualPend   = rawPend & enReg;
  assign irqReq     = |(qualPend & ~selReg);
  assign fiqReq     = |(qualPend & selReg);
  assign edgeClrVec = strb.edgeClr ? (wideData & ~senseVec) : '0;

  always_comb begin
    case (strb.rdSrc)
      RD_IRQST:  rdVec = qualPend & ~selReg;
      RD_FIQST:  rdVec = qualPend & selReg;
      RD_RAW:    rdVec = rawPend;
      RD_SEL:    rdVec = selReg;
      RD_EN:     rdVec = enReg;
      RD_SENSE:  rdVec = senseVec;
      RD_BOTH:   rdVec = bothVec;
      RD_POL:    rdVec = polVec;
      RD_EDGEST: rdVec = rawPend & ~senseVec;
      default:   rdVec = '0;
    endcase
  end

  assign rdPad = PAD_W'(rdVec);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign wordArr[w] = rdPad[w*DATA_W +: DATA_W];
  end

  assign rdata = wordArr[strb.hiWord];

endmodule

// File: rtl/irq_fiq_regbank.sv
module irq_fiq_regbank
  import irqbank_pkg::*;
#(
  parameter int NUM_SRC = 51,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int POL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] rawPend,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [NUM_SRC-1:0] senseLvl,
  output logic [NUM_SRC-1:0] polHigh,
  output logic [NUM_SRC-1:0] bothEdge,
  output logic [NUM_SRC-1:0] edgeClr
);

  ctrlStrobeT strb;

  irqbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regSel (regSel),
    .regWr  (regWr),
    .regAddr(regAddr),
    .strb   (strb)
  );

  irqbank_dp #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W),
    .POL_W  (POL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (regWdata),
    .rawPend   (rawPend),
    .rdata     (regRdata),
    .irqReq    (irqOut),
    .fiqReq    (fiqOut),
    .senseVec  (senseLvl),
    .bothVec   (bothEdge),
    .polVec    (polHigh),
    .edgeClrVec(edgeClr)
  );

endmodule

// File: rtl/irq_fiq_regbank_chk.sv
module irq_fiq_regbank_chk #(
  parameter int NUM_SRC = 51,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regSel,
  input logic               regWr,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdata,
  input logic [NUM_SRC-1:0] rawPend,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [NUM_SRC-1:0] senseLvl,
  input logic [NUM_SRC-1:0] polHigh,
  input logic [NUM_SRC-1:0] edgeClr
);

  localparam int HI_W = NUM_SRC - DATA_W;

  p_edgeclr_edge_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (edgeClr & senseLvl) == '0);

  p_edgeclr_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(regSel && regWr) |-> edgeClr == '0);

  p_no_req_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    rawPend == '0 |-> !irqOut && !fiqOut);

  p_hi_word_pad_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && regAddr >= ADDR_W'('h80) && regAddr[2])
      |-> regRdata[DATA_W-1:HI_W] == '0);

  p_wo_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWr && (regAddr == ADDR_W'('hA8) || regAddr == ADDR_W'('hB8) ||
                          regAddr == ADDR_W'('hD8) || regAddr == ADDR_W'('hB0)))
      |-> regRdata == '0);

  p_pol_low_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWr && regAddr == ADDR_W'('hD0)) |=> $stable(polHigh));

endmodule

bind irq_fiq_regbank irq_fiq_regbank_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regSel  (regSel),
  .regWr   (regWr),
  .regAddr (regAddr),
  .regRdata(regRdata),
  .rawPend (rawPend),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .senseLvl(senseLvl),
  .polHigh (polHigh),
  .edgeClr (edgeClr)
);

// File: tb/sim_irq_fiq_regbank.sv
module sim_irq_fiq_regbank;

  localparam logic [50:0] M_SENSE   = 51'h1F07FFF8FFFF;
  localparam logic [50:0] M_BOTH    = 51'h00F800070000;
  localparam logic [50:0] M_POL_RST = 51'h5F07FFF8FFFF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regSel, regWr;
  logic [7:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic [50:0] rawPend;
  logic        irqOut, fiqOut;
  logic [50:0] senseLvl, polHigh, bothEdge, edgeClr;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  logic [50:0] mEn, mSel, mPol;
  logic [31:0] lastRd;

  always #4 clk = ~clk;

  irq_fiq_regbank u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rawPend(rawPend),
    .irqOut(irqOut), .fiqOut(fiqOut), .senseLvl(senseLvl), .polHigh(polHigh),
    .bothEdge(bothEdge), .edgeClr(edgeClr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic isHi(logic [7:0] a);
    return (a >= 8'h80) && a[2];
  endfunction

  function automatic logic [7:0] normOf(logic [7:0] a);
    return (a >= 8'h80) ? (a & 8'hFB) : a;
  endfunction

  function automatic logic [50:0] placeWord(logic [7:0] a, logic [31:0] d);
    return isHi(a) ? {d[18:0], 32'h0} : {19'h0, d};
  endfunction

  function automatic logic [31:0] expRd(logic [7:0] a, logic [50:0] raw);
    logic [50:0] v;
    case (normOf(a))
      8'h80, 8'h00: v = raw & mEn & ~mSel;
      8'h88, 8'h04: v = raw & mEn & mSel;
      8'h90, 8'h08: v = raw;
      8'h98, 8'h0C: v = mSel;
      8'hA0, 8'h10: v = mEn;
      8'hC0, 8'h24: v = M_SENSE;
      8'hC8, 8'h28: v = M_BOTH;
      8'hD0, 8'h2C: v = mPol;
      8'hE0:        v = raw & ~M_SENSE;
      default:      v = '0;
    endcase
    return isHi(a) ? {13'h0, v[50:32]} : v[31:0];
  endfunction

  function automatic logic [50:0] expClr(logic [7:0] a, logic [31:0] d);
    logic [7:0] n = normOf(a);
    if (n == 8'hD8 || n == 8'h38) return placeWord(a, d) & ~M_SENSE;
    return '0;
  endfunction

  task automatic modelWrite(logic [7:0] a, logic [31:0] d);
    logic [50:0] w = placeWord(a, d);
    case (normOf(a))
      8'h98, 8'h0C: if (isHi(a)) mSel[50:32] = d[18:0]; else mSel[31:0] = d;
      8'hA0, 8'h10: mEn = mEn | w;
      8'hA8, 8'h14: mEn = mEn & ~w;
      8'hD0:        if (isHi(a)) mPol[50:47] = w[50:47];
      default: ;
    endcase
  endtask

  // one register-port cycle, checks taken mid-cycle
  task automatic op(bit wr, logic [7:0] a, logic [31:0] d, logic [50:0] raw);
    @(negedge clk);
    regSel = 1'b1; regWr = wr; regAddr = a; regWdata = d; rawPend = raw;
    #1;
    chk("R5 irqOut", 64'(irqOut), 64'(|(raw & mEn & ~mSel)));
    chk("R5 fiqOut", 64'(fiqOut), 64'(|(raw & mEn & mSel)));
    chk("R9 edgeClr", 64'(edgeClr), 64'(wr ? expClr(a, d) : 51'h0));
    chk("R6 senseLvl/bothEdge", {senseLvl[31:0], bothEdge[31:0]}, {M_SENSE[31:0], M_BOTH[31:0]});
    chk("R8 polHigh", 64'(polHigh), 64'(mPol));
    if (!wr) begin
      lastRd = regRdata;
      chk($sformatf("R1/R2/R10 read %h", a), 64'(regRdata), 64'(expRd(a, raw)));
    end
    @(posedge clk);
    if (wr) modelWrite(a, d);
    #1 regSel = 1'b0;
  endtask

  localparam int NADDR = 24;
  logic [7:0] addrList [NADDR] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'h98, 8'h9C,
                                   8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hB0, 8'hC0, 8'hC4, 8'hD0,
                                   8'hD4, 8'hD8, 8'hDC, 8'hE0, 8'h0C, 8'h10, 8'h14, 8'h38};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [50:0] ones = '1;
    void'($urandom(32'h5A17_2C3D));
    mEn = '0; mSel = '0; mPol = M_POL_RST;
    regSel = 0; regWr = 0; regAddr = 0; regWdata = 0; rawPend = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R12 reset state
    op(0, 8'hA0, 0, ones); chk("R12 enable reset", 64'(lastRd), 64'h0);
    op(0, 8'h98, 0, ones); chk("R12 select reset", 64'(lastRd), 64'h0);
    chk("R12 outputs low", {63'h0, irqOut | fiqOut}, 64'h0);
    // R6 constants
    op(0, 8'hC0, 0, 0); chk("R6 sense low", 64'(lastRd), 64'hFFF8FFFF);
    op(0, 8'hC4, 0, 0); chk("R6 sense high", 64'(lastRd), 64'h1F07);
    op(0, 8'h28, 0, 0); chk("R6 both compact", 64'(lastRd), 64'h00070000);
    op(0, 8'hCC, 0, 0); chk("R6 both high", 64'(lastRd), 64'hF8);
    // R4, R3, R2
    op(1, 8'hA0, 32'hFF, 0);
    op(1, 8'h98, 32'h0F, ones);
    op(0, 8'h80, 0, ones); chk("R2 irq status", 64'(lastRd), 64'hF0);
    op(0, 8'h04, 0, ones); chk("R2 fiq status compact", 64'(lastRd), 64'h0F);
    op(1, 8'h9C, 32'hFFFF_FFFF, ones);
    op(0, 8'h98, 0, 0); chk("R3 low word kept", 64'(lastRd), 64'h0F);
    op(0, 8'h9C, 0, 0); chk("R3 high word written", 64'(lastRd), 64'h7FFFF);
    op(1, 8'hA8, 32'h0F, ones);
    op(0, 8'hA0, 0, 0); chk("R4 enable clear", 64'(lastRd), 64'hF0);
    op(1, 8'h14, 32'h10, ones);
    op(0, 8'h10, 0, 0); chk("R4 compact clear", 64'(lastRd), 64'hE0);
    // R8 polarity
    op(1, 8'hD0, 32'hFFFF_FFFF, 0);
    op(0, 8'hD0, 0, 0); chk("R8 low write ignored", 64'(lastRd), 64'hFFF8FFFF);
    op(1, 8'hD4, 32'hFFFF_FFFF, 0);
    op(0, 8'hD4, 0, 0); chk("R8 top four written", 64'(lastRd), 64'h7DF07);
    op(0, 8'h2C, 0, 0); chk("R8 compact read", 64'(lastRd), 64'hFFF8FFFF);
    // R9 edge clear (checked inside op) and R7
    op(1, 8'hD8, 32'hFFFF_FFFF, 0);
    op(1, 8'hDC, 32'hFFFF_FFFF, 0);
    op(1, 8'h38, 32'h0001_0000, 0);
    op(0, 8'hE0, 0, ones); chk("R7 edge status low", 64'(lastRd), 64'h00070000);
    op(0, 8'hE4, 0, ones); chk("R7 edge status high", 64'(lastRd), 64'h7E0F8);
    // R11, R10, R1
    op(1, 8'hC0, 32'h0, 0);
    op(0, 8'hC0, 0, 0); chk("R11 read-only write", 64'(lastRd), 64'hFFF8FFFF);
    op(1, 8'hB0, 32'hFFFF_FFFF, ones);
    op(1, 8'h1C, 32'hFFFF_FFFF, ones);
    op(0, 8'hB0, 0, ones); chk("R10 swi reads zero", 64'(lastRd), 64'h0);
    op(0, 8'hA8, 0, ones); chk("R10 write-only zero", 64'(lastRd), 64'h0);
    op(0, 8'h94, 0, ones); chk("R1 high pad", 64'(lastRd), 64'h7FFFF);
    op(0, 8'h08, 0, ones); chk("R1 compact low word", 64'(lastRd), 64'hFFFF_FFFF);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [50:0] raw;
      if ($urandom_range(1, 0) == 0) a = addrList[$urandom_range(NADDR-1, 0)];
      else a = {$urandom_range(63, 0), 2'b00};
      raw = {$urandom, $urandom};
      if ($urandom_range(3, 0) == 0) raw = '0;
      else if ($urandom_range(1, 0) == 0) raw = raw & {$urandom, $urandom};
      op($urandom_range(1, 0) == 1, a, $urandom, raw);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule